// File: doc/BRIEF.md
# Translation Unit Control Register Block

This block is the software-facing control plane of an address translation unit. A simple register bus writes and reads a small set of 32-bit registers. From these, the block drives the page-table walker and the TLB. Software uses it to:

- switch translation on or off;
- park incoming traffic in a blocked state;
- program the root of the page table as a page frame number;
- discard cached translations, either all of them or the one entry that covers a given virtual address.

Blocking is a handshake. A block request first waits until in-flight translations have drained. Only then does the status register report that traffic is held. The drain time is modelled by a cycle count on an input port, sampled when the request is made. Loading a new table root always discards the whole TLB, so no stale entry survives a change of address space. The TLB and the walker sit outside this block.

Top module: `xlat_ctl_regs`

## Requirements
- R1: After reset, translation is off, nothing is held or blocked, and the configuration word and page frame number are 0. Neither invalidate output pulses, and the read data is 0.
- R2: Writing 0x5 to the control register (offset 0x000) sets the mode to on: xlat_en=1 and hold_traffic=0. Writing 0x0 sets the mode to off: xlat_en=0 and hold_traffic=0. From the cycle after the write edge, the control register reads back 0x5, 0x7 or 0x0 according to the mode.
- R3: Writing 0x7 to the control register requests the blocked mode, in which xlat_en=1 and hold_traffic=1. A control write of any other value leaves the mode unchanged.
- R4: Let D be the value of drain_cycles at the edge where a block request arrives from a mode other than blocked. Bit 0 of the status register (offset 0x008) and blocked_ack become 1 exactly D+1 edges after that write edge. They stay 1 while the mode remains blocked. Writing 0x7 again while already blocked does not restart the count.
- R5: A control write that leaves the blocked mode clears blocked_ack and status bit 0 at that same write edge.
- R6: The version register (offset 0x034) reads {VER_MAJ[3:0], VER_MIN[6:0], 21'b0}, which places the major version in bits 31:28 and the minor version in bits 27:21. Writes to it have no effect.
- R7: The configuration register (offset 0x004) is a 32-bit read/write word.
- R8: A write to offset 0x00C stores wdata[PFN_W-1:0] as the page frame number. pt_base_pfn presents it from the cycle after the write. A read of that offset returns it zero-extended.
- R9: Every write of the page frame number produces a one-cycle inv_all pulse in the cycle after the write edge.
- R10: A write to offset 0x010 with bit 0 set produces a one-cycle inv_all pulse in the cycle after the write edge. The same write with bit 0 clear produces no pulse.
- R11: A write to offset 0x014 with bit 0 set produces a one-cycle inv_entry pulse in the cycle after the write edge, with inv_vpn = wdata[31:12]. With bit 0 clear, the write produces no pulse and inv_vpn keeps its value.
- R12: bus_rdata is loaded only on a cycle with bus_rd=1 and shows the value in the following cycle. A read of an unmapped offset, or of an address whose two low bits are not 0, returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | AW | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| drain_cycles | input | CW | Cycles needed for in-flight traffic to drain after a block request |
| xlat_en | output | 1 | Translation is active (mode on or blocked) |
| hold_traffic | output | 1 | Block requested; the walker must stop accepting traffic |
| blocked_ack | output | 1 | Drain complete; traffic is held |
| pt_base_pfn | output | PFN_W | Page frame number of the page-table root |
| inv_all | output | 1 | One-cycle pulse: discard all TLB entries |
| inv_entry | output | 1 | One-cycle pulse: discard the TLB entry for inv_vpn |
| inv_vpn | output | VPN_W | Virtual page number of the entry to discard |

## Verification
The bench builds the block with a 4-bit drain counter. This makes both a zero-cycle drain and the longest drain of 15 cycles reachable within a short run, along with a re-request in the middle of a drain. The page frame number is 24 bits wide, so a write with non-zero upper bits shows that only the low bits are kept. The version is set to major 5, minor 3, so both fields land at non-zero positions that a swapped or shifted field would visibly break.

// File: rtl/xlat_ctl_pkg.sv
package xlat_ctl_pkg;

  typedef enum logic [1:0] {
    MODE_OFF  = 2'd0,
    MODE_ON   = 2'd1,
    MODE_HOLD = 2'd2
  } mode_e;

  // register byte offsets
  localparam logic [11:0] OFS_CTRL  = 12'h000;
  localparam logic [11:0] OFS_CFG   = 12'h004;
  localparam logic [11:0] OFS_STAT  = 12'h008;
  localparam logic [11:0] OFS_PFN   = 12'h00C;
  localparam logic [11:0] OFS_FLALL = 12'h010;
  localparam logic [11:0] OFS_FLENT = 12'h014;
  localparam logic [11:0] OFS_VER   = 12'h034;

  // control command codes
  localparam logic [31:0] CODE_OFF  = 32'h0;
  localparam logic [31:0] CODE_ON   = 32'h5;
  localparam logic [31:0] CODE_HOLD = 32'h7;

  typedef struct packed {
    logic ctrl;
    logic cfg;
    logic stat;
    logic pfn;
    logic flall;
    logic flent;
    logic ver;
  } sel_t;

endpackage

// File: rtl/xlat_ctl_decode.sv
module xlat_ctl_decode
  import xlat_ctl_pkg::*;
#(
  parameter int AW = 12
) (
  input  logic [AW-1:0] addr,
  output sel_t          sel
);
  localparam int WW = AW - 2;

  logic          aligned;
  logic [WW-1:0] word;

  assign aligned = (addr[1:0] == 2'b00);
  assign word    = addr[AW-1:2];

  always_comb begin
    sel.ctrl  = aligned && (word == WW'(OFS_CTRL  >> 2));
    sel.cfg   = aligned && (word == WW'(OFS_CFG   >> 2));
    sel.stat  = aligned && (word == WW'(OFS_STAT  >> 2));
    sel.pfn   = aligned && (word == WW'(OFS_PFN   >> 2));
    sel.flall = aligned && (word == WW'(OFS_FLALL >> 2));
    sel.flent = aligned && (word == WW'(OFS_FLENT >> 2));
    sel.ver   = aligned && (word == WW'(OFS_VER   >> 2));
  end
endmodule

// File: rtl/xlat_ctl_hold.sv
module xlat_ctl_hold #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hold_q,
  input  logic          hold_nx,
  input  logic [CW-1:0] drain_cycles,
  output logic          blocked
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          blk_d;

  always_comb begin
    cnt_d = cnt_q;
    blk_d = blocked;
    if (!hold_nx) begin
      cnt_d = '0;
      blk_d = 1'b0;
    end else if (!hold_q) begin
      cnt_d = drain_cycles;
      blk_d = 1'b0;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end else begin
      blk_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      blocked <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      blocked <= blk_d;
    end
  end
endmodule

// File: rtl/xlat_ctl_invgen.sv
module xlat_ctl_invgen #(
  parameter int VPN_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             all_req,
  input  logic             ent_req,
  input  logic [VPN_W-1:0] ent_vpn,
  output logic             inv_all,
  output logic             inv_entry,
  output logic [VPN_W-1:0] inv_vpn
);
  logic             all_d, ent_d, vpn_en;
  logic [VPN_W-1:0] vpn_d;

  always_comb begin
    all_d  = all_req;
    ent_d  = ent_req;
    vpn_en = ent_req;
    vpn_d  = ent_vpn;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inv_all   <= 1'b0;
      inv_entry <= 1'b0;
    end else begin
      inv_all   <= all_d;
      inv_entry <= ent_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      inv_vpn <= '0;
    else if (vpn_en) inv_vpn <= vpn_d;
  end
endmodule

// File: rtl/xlat_ctl_regs.sv
module xlat_ctl_regs
  import xlat_ctl_pkg::*;
#(
  parameter int AW      = 12,
  parameter int PFN_W   = 24,
  parameter int CW      = 8,
  parameter int VA_W    = 32,
  parameter int VER_MAJ = 5,
  parameter int VER_MIN = 0,
  localparam int PAGE_SHIFT = 12,
  localparam int VPN_W      = VA_W - PAGE_SHIFT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [AW-1:0]    bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  input  logic [CW-1:0]    drain_cycles,
  output logic             xlat_en,
  output logic             hold_traffic,
  output logic             blocked_ack,
  output logic [PFN_W-1:0] pt_base_pfn,
  output logic             inv_all,
  output logic             inv_entry,
  output logic [VPN_W-1:0] inv_vpn
);
  localparam logic [31:0] VER_WORD =
    32'(((VER_MAJ & 15) << 28) | ((VER_MIN & 127) << 21));

  sel_t             sel;
  mode_e            mode_q, mode_d;
  logic [31:0]      cfg_q;
  logic [PFN_W-1:0] pfn_q;
  logic [31:0]      rdata_q, rd_val;
  logic             cfg_we, pfn_we, all_req, ent_req;
  logic             hold_q, hold_nx;
  logic [31:0]      ctrl_word;

  xlat_ctl_decode #(.AW(AW)) u_dec (
    .addr (bus_addr),
    .sel  (sel)
  );

  // next-state for mode and write enables
  always_comb begin
    mode_d = mode_q;
    if (bus_wr && sel.ctrl) begin
      case (bus_wdata)
        CODE_ON:   mode_d = MODE_ON;
        CODE_HOLD: mode_d = MODE_HOLD;
        CODE_OFF:  mode_d = MODE_OFF;
        default:   mode_d = mode_q;
      endcase
    end
    cfg_we  = bus_wr && sel.cfg;
    pfn_we  = bus_wr && sel.pfn;
    all_req = pfn_we || (bus_wr && sel.flall && bus_wdata[0]);
    ent_req = bus_wr && sel.flent && bus_wdata[0];
    hold_q  = (mode_q == MODE_HOLD);
    hold_nx = (mode_d == MODE_HOLD);
  end

  // read mux
  always_comb begin
    case (mode_q)
      MODE_ON:   ctrl_word = CODE_ON;
      MODE_HOLD: ctrl_word = CODE_HOLD;
      default:   ctrl_word = CODE_OFF;
    endcase
    rd_val = '0;
    if (sel.ctrl) rd_val = ctrl_word;
    if (sel.cfg)  rd_val = cfg_q;
    if (sel.stat) rd_val = {31'b0, blocked_ack};
    if (sel.pfn)  rd_val = 32'(pfn_q);
    if (sel.ver)  rd_val = VER_WORD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= MODE_OFF;
    else        mode_q <= mode_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= '0;
    else if (cfg_we) cfg_q <= bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pfn_q <= '0;
    else if (pfn_we) pfn_q <= bus_wdata[PFN_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (bus_rd) rdata_q <= rd_val;
  end

  xlat_ctl_hold #(.CW(CW)) u_hold (
    .clk          (clk),
    .rst_n        (rst_n),
    .hold_q       (hold_q),
    .hold_nx      (hold_nx),
    .drain_cycles (drain_cycles),
    .blocked      (blocked_ack)
  );

  xlat_ctl_invgen #(.VPN_W(VPN_W)) u_inv (
    .clk       (clk),
    .rst_n     (rst_n),
    .all_req   (all_req),
    .ent_req   (ent_req),
    .ent_vpn   (bus_wdata[VA_W-1:PAGE_SHIFT]),
    .inv_all   (inv_all),
    .inv_entry (inv_entry),
    .inv_vpn   (inv_vpn)
  );

  assign bus_rdata    = rdata_q;
  assign xlat_en      = (mode_q != MODE_OFF);
  assign hold_traffic = hold_q;
  assign pt_base_pfn  = pfn_q;
endmodule

// File: rtl/xlat_ctl_sva.sv
module xlat_ctl_sva
  import xlat_ctl_pkg::*;
#(
  parameter int AW    = 12,
  parameter int PFN_W = 24,
  parameter int VPN_W = 20
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_wr,
  input logic [AW-1:0]    bus_addr,
  input logic [31:0]      bus_wdata,
  input logic             xlat_en,
  input logic             hold_traffic,
  input logic             blocked_ack,
  input logic [PFN_W-1:0] pt_base_pfn,
  input logic             inv_all,
  input logic             inv_entry,
  input logic [VPN_W-1:0] inv_vpn
);
  logic pfn_wr, ent_wr;
  assign pfn_wr = bus_wr && (bus_addr == AW'(OFS_PFN));
  assign ent_wr = bus_wr && (bus_addr == AW'(OFS_FLENT)) && bus_wdata[0];

  p_hold_implies_en_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hold_traffic |-> xlat_en);

  p_ack_needs_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    blocked_ack |-> hold_traffic);

  p_leave_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_traffic) |-> !blocked_ack);

  p_pfn_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !pfn_wr |=> $stable(pt_base_pfn));

  p_pfn_flush_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pfn_wr |=> inv_all);

  p_entry_vpn_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ent_wr |=> (inv_entry && inv_vpn == $past(bus_wdata[31:32-VPN_W])));
endmodule

bind xlat_ctl_regs xlat_ctl_sva #(.AW(AW), .PFN_W(PFN_W), .VPN_W(VPN_W)) u_sva (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_wr       (bus_wr),
  .bus_addr     (bus_addr),
  .bus_wdata    (bus_wdata),
  .xlat_en      (xlat_en),
  .hold_traffic (hold_traffic),
  .blocked_ack  (blocked_ack),
  .pt_base_pfn  (pt_base_pfn),
  .inv_all      (inv_all),
  .inv_entry    (inv_entry),
  .inv_vpn      (inv_vpn)
);

// File: tb/xlat_ctl_regs_tb.sv
module xlat_ctl_regs_tb;
  localparam int AW = 12, PFN_W = 24, CW = 4, VPN_W = 20;
  localparam logic [31:0] VERW = 32'h5060_0000;

  logic             clk, rst_n, bus_wr, bus_rd;
  logic [AW-1:0]    bus_addr;
  logic [31:0]      bus_wdata, bus_rdata;
  logic [CW-1:0]    drain_cycles;
  logic             xlat_en, hold_traffic, blocked_ack, inv_all, inv_entry;
  logic [PFN_W-1:0] pt_base_pfn;
  logic [VPN_W-1:0] inv_vpn;

  int errors = 0, checks = 0;
  bit done = 0;

  xlat_ctl_regs #(.AW(AW), .PFN_W(PFN_W), .CW(CW), .VA_W(32),
                  .VER_MAJ(5), .VER_MIN(3)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .drain_cycles(drain_cycles), .xlat_en(xlat_en), .hold_traffic(hold_traffic),
    .blocked_ack(blocked_ack), .pt_base_pfn(pt_base_pfn), .inv_all(inv_all),
    .inv_entry(inv_entry), .inv_vpn(inv_vpn));

  initial clk = 0;
  always #5 clk = ~clk;

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // behavioural reference model: mode 0=off 1=on 2=blocked
  int m_mode, m_cnt, m_blk, m_all, m_ent;
  longint m_cfg, m_pfn, m_vpn, m_rd;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_cnt = 0; m_blk = 0; m_all = 0; m_ent = 0;
      m_cfg = 0; m_pfn = 0; m_vpn = 0; m_rd = 0;
    end else begin
      longint rv;
      int nmode, was_hold;
      rv = 0;
      if (bus_rd && bus_addr[1:0] == 0) begin
        case (bus_addr)
          12'h000: rv = (m_mode == 1) ? 5 : (m_mode == 2) ? 7 : 0;
          12'h004: rv = m_cfg;
          12'h008: rv = m_blk;
          12'h00C: rv = m_pfn;
          12'h034: rv = VERW;
          default: rv = 0;
        endcase
      end
      if (bus_rd) m_rd = rv;
      nmode = m_mode;
      was_hold = (m_mode == 2);
      m_all = 0; m_ent = 0;
      if (bus_wr) begin
        case (bus_addr)
          12'h000: if (bus_wdata == 5) nmode = 1;
                   else if (bus_wdata == 7) nmode = 2;
                   else if (bus_wdata == 0) nmode = 0;
          12'h004: m_cfg = bus_wdata;
          12'h00C: begin m_pfn = bus_wdata % (1 << 24); m_all = 1; end
          12'h010: if (bus_wdata[0]) m_all = 1;
          12'h014: if (bus_wdata[0]) begin m_ent = 1; m_vpn = bus_wdata >> 12; end
          default: ;
        endcase
      end
      if (nmode != 2) begin m_blk = 0; m_cnt = 0; end
      else if (!was_hold) begin m_blk = 0; m_cnt = drain_cycles; end
      else if (m_cnt > 0) m_cnt--;
      else m_blk = 1;
      m_mode = nmode;
    end
  end

  always @(negedge clk) if (rst_n && !done) begin
    chk("R2", "xlat_en", xlat_en, m_mode != 0);
    chk("R3", "hold_traffic", hold_traffic, m_mode == 2);
    chk("R4", "blocked_ack", blocked_ack, m_blk);
    chk("R8", "pt_base_pfn", pt_base_pfn, m_pfn);
    chk("R10", "inv_all", inv_all, m_all);
    chk("R11", "inv_entry", inv_entry, m_ent);
    chk("R11", "inv_vpn", inv_vpn, m_vpn);
    chk("R12", "bus_rdata", bus_rdata, m_rd);
  end

  task automatic wr(logic [AW-1:0] a, logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(logic [AW-1:0] a, logic [31:0] exp, string req);
    @(negedge clk); bus_rd = 1; bus_addr = a;
    @(negedge clk); bus_rd = 0;
    chk(req, "read", bus_rdata, exp);
  endtask

  initial begin
    bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0; drain_cycles = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    // R1 reset state
    chk("R1", "xlat_en", xlat_en, 0);
    chk("R1", "blocked", blocked_ack, 0);
    chk("R1", "inv_all", inv_all, 0);
    chk("R1", "rdata", bus_rdata, 0);
    rd(12'h000, 0, "R1");
    rd(12'h004, 0, "R1");
    rd(12'h00C, 0, "R1");
    rd(12'h034, VERW, "R6");
    // R2 enable, R3 invalid code ignored
    wr(12'h000, 5);
    chk("R2", "xlat_en on", xlat_en, 1);
    rd(12'h000, 5, "R2");
    wr(12'h000, 3);
    rd(12'h000, 5, "R3");
    // R7 config
    wr(12'h004, 32'hA5A5_1234);
    rd(12'h004, 32'hA5A5_1234, "R7");
    // R6 version write ignored
    wr(12'h034, 32'hFFFF_FFFF);
    rd(12'h034, VERW, "R6");
    // R8/R9 page frame number
    wr(12'h00C, 32'hAB65_4321);
    chk("R9", "inv_all after pfn", inv_all, 1);
    chk("R8", "pfn", pt_base_pfn, 24'h654321);
    @(negedge clk);
    chk("R9", "inv_all one cycle", inv_all, 0);
    rd(12'h00C, 32'h0065_4321, "R8");
    // R10 flush all
    wr(12'h010, 1);
    chk("R10", "inv_all pulse", inv_all, 1);
    wr(12'h010, 0);
    chk("R10", "inv_all ignored", inv_all, 0);
    // R11 flush entry
    wr(12'h014, 32'hDEAD_B001);
    chk("R11", "inv_entry pulse", inv_entry, 1);
    chk("R11", "inv_vpn", inv_vpn, 20'hDEADB);
    wr(12'h014, 32'h1234_5000);
    chk("R11", "inv_entry ignored", inv_entry, 0);
    chk("R11", "inv_vpn kept", inv_vpn, 20'hDEADB);
    // R12 unmapped and misaligned
    rd(12'h020, 0, "R12");
    rd(12'h001, 0, "R12");
    // R4 drain of 3
    drain_cycles = 3;
    wr(12'h000, 7);
    chk("R3", "hold", hold_traffic, 1);
    for (int i = 1; i <= 3; i++) begin
      @(negedge clk); chk("R4", "not yet blocked", blocked_ack, 0);
    end
    @(negedge clk); chk("R4", "blocked at D+1", blocked_ack, 1);
    rd(12'h008, 1, "R4");
    // R5 leave
    wr(12'h000, 5);
    chk("R5", "blocked cleared", blocked_ack, 0);
    // R4 re-request mid-drain, max drain
    drain_cycles = 15;
    wr(12'h000, 7);
    drain_cycles = 0;
    wr(12'h000, 7);
    repeat (10) @(negedge clk);
    chk("R4", "no restart", blocked_ack, 0);
    repeat (6) @(negedge clk);
    chk("R4", "blocked after max drain", blocked_ack, 1);
    // R4 zero drain
    wr(12'h000, 0);
    chk("R2", "off", xlat_en, 0);
    wr(12'h000, 7);
    @(negedge clk);
    chk("R4", "zero drain", blocked_ack, 1);
    wr(12'h000, 0);
    chk("R5", "off clears", blocked_ack, 0);
    repeat (3) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule